// File: doc/BRIEF.md
# Colour Channel Sampling Sequencer

This block decides which colour input (red, green or blue) the converter samples on each converter clock. It runs in the converter clock domain and steps one channel per rising edge. In three-colour cycling it rotates through all three colours, in either red-first or blue-first order. A pixel data-clock pulse restarts the rotation at the first colour of that order. In two-colour mode it alternates between the two colours picked by a three-bit select mask. In single-colour mode it stays on the one selected colour.

The pixel pulse comes from another timing domain. It passes through a two-flop synchroniser and its rising edge is detected locally. Each output sample carries a one-hot select and a two-bit colour tag. A valid flag is low whenever no colour is chosen. The analog multiplexer itself is not part of this block.

Top module: `chan_seq`

## Requirements
- R1: With `tri_mode` high and `order_fwd` high, the tag steps 0 (red), 1 (green), 2 (blue) and then back to 0, one step per rising clock edge.
- R2: With `tri_mode` high and `order_fwd` low, the tag steps 2 (blue), 1 (green), 0 (red) and then back to 2, one step per rising clock edge.
- R3: In three-colour cycling, a low-to-high transition of `pix_clk` that is present before rising clock edge k forces the tag to the first colour of the order at edge k+2. The first colour is 0 when `order_fwd` is high and 2 when it is low. A level that stays high causes no further restart.
- R4: With `tri_mode` low and exactly two bits of `sel_mask` set, the tag alternates between those two colours. The colour with the lower tag comes first when `order_fwd` is high, and the higher one comes first when it is low. The mask bits are bit 0 red, bit 1 green and bit 2 blue.
- R5: With `tri_mode` low and exactly one bit of `sel_mask` set, the tag stays on that colour from the next clock edge onward.
- R6: With `tri_mode` low and `sel_mask` zero, the next edge drives the tag to 3, `chan_sel` to zero and `smp_valid` low.
- R7: With `tri_mode` low and all three `sel_mask` bits set, the block behaves exactly as three-colour cycling, including the restart.
- R8: During reset the tag is 3 and `smp_valid` is low. The first edge after reset selects the first active colour of the order.
- R9: `chan_sel` has bit t set when the tag is t (0 to 2) and is zero when the tag is 3. `smp_valid` is high exactly when a colour is selected.
- R10: Outside three-colour cycling, the `pix_clk` edge has no effect on the sequence. If the mask changes and drops the current colour, the next edge moves to the first active colour of the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter sample clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| pix_clk | input | 1 | Pixel data-clock pulse, asynchronous to clk |
| tri_mode | input | 1 | Three-colour cycling enable |
| order_fwd | input | 1 | 1 = red-green-blue order, 0 = blue-green-red order |
| sel_mask | input | 3 | Colour select: bit 0 red, bit 1 green, bit 2 blue |
| chan_sel | output | 3 | One-hot selected colour |
| chan_tag | output | 2 | Colour tag of the sample: 0 red, 1 green, 2 blue, 3 none |
| smp_valid | output | 1 | A colour is selected this cycle |

## Verification
Some properties hold on every cycle, and the embedded assertions check these. The select is one-hot or empty. A single-colour setting pins the output. An empty mask gives no valid sample. A detected pixel edge restarts three-colour cycling at red or blue. The single forward steps are also checked in three-colour and two-colour mode.

Other behaviour only shows up over a sequence of cycles, and the bench scenarios are needed for it. This covers the full rotation and its wrap, and the exact two-edge synchroniser latency. It also covers the absence of a restart while `pix_clk` stays high, and recovery after a mask change drops the current colour. The bench sweeps every mode, order and mask combination against its own model.

// File: rtl/chan_seq.sv
module chan_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pix_clk,
  input  logic       tri_mode,
  input  logic       order_fwd,
  input  logic [2:0] sel_mask,
  output logic [2:0] chan_sel,
  output logic [1:0] chan_tag,
  output logic       smp_valid
);

  localparam logic [1:0] NONE = 2'd3;

  logic [2:0] sync_q;
  logic       rise;
  logic [2:0] act;
  logic [2:0] actp;
  logic       eff3;
  logic [1:0] cur_q;
  logic [1:0] cur_pos;
  logic [1:0] first_pos;
  logic [1:0] next_pos;
  logic       cur_ok;
  logic [1:0] nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], pix_clk};
  end

  assign rise = sync_q[1] & ~sync_q[2];
  assign act  = tri_mode ? 3'b111 : sel_mask;
  assign eff3 = (act == 3'b111);
  assign actp = order_fwd ? act : {act[0], act[1], act[2]};

  assign cur_pos = order_fwd ? cur_q : 2'(2 - cur_q);
  assign cur_ok  = (cur_q != NONE) && act[cur_q[1] ? 2 : (cur_q[0] ? 1 : 0)];

  always_comb begin
    first_pos = 2'd0;
    if (actp[0])      first_pos = 2'd0;
    else if (actp[1]) first_pos = 2'd1;
    else              first_pos = 2'd2;
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    next_pos = cur_pos;
    for (int k = 1; k <= 3; k++) begin
      logic [1:0] p;
      p = 2'((int'(cur_pos) + k) % 3);
      if (!found && actp[p]) begin
        next_pos = p;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    if (act == 3'b000)
      nxt = NONE;
    else if (!cur_ok || (eff3 && rise))
      nxt = order_fwd ? first_pos : 2'(2 - first_pos);
    else
      nxt = order_fwd ? next_pos : 2'(2 - next_pos);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur_q <= NONE;
    else        cur_q <= nxt;
  end

  assign chan_tag  = cur_q;
  assign smp_valid = (cur_q != NONE);
  assign chan_sel  = smp_valid ? (3'b001 << cur_q) : 3'b000;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_sel)); // R9
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tri_mode && sel_mask == 3'b000) |=> (!smp_valid && chan_sel == 3'b000)); // R6
  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tri_mode && $onehot(sel_mask)) |=> (chan_sel == $past(sel_mask))); // R5
  AST_RESTART_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (eff3 && rise && order_fwd) |=> (chan_tag == 2'd0)); // R3
  AST_RESTART_REV: assert property (@(posedge clk) disable iff (!rst_n)
    (eff3 && rise && !order_fwd) |=> (chan_tag == 2'd2)); // R3
  AST_FWD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tri_mode && !rise && order_fwd && chan_tag == 2'd0) |=> (chan_tag == 2'd1)); // R1
  AST_REV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tri_mode && !rise && !order_fwd && chan_tag == 2'd2) |=> (chan_tag == 2'd1)); // R2
  AST_PAIR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!tri_mode && sel_mask == 3'b101 && chan_tag == 2'd0) |=> (chan_tag == 2'd2)); // R4

endmodule

// File: tb/chan_seq_tb_top.sv
`timescale 1ns/1ps
module chan_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_clk = 1'b0;
  logic       tri_mode = 1'b0;
  logic       order_fwd = 1'b1;
  logic [2:0] sel_mask = 3'b000;
  logic [2:0] chan_sel;
  logic [1:0] chan_tag;
  logic       smp_valid;

  int checks = 0;
  int errors = 0;
  logic [1:0] exp_tag = 2'd3;
  logic [2:0] psh = 3'b000;

  always #2.5 clk = ~clk;

  chan_seq dut_i (
    .clk(clk), .rst_n(rst_n), .pix_clk(pix_clk), .tri_mode(tri_mode),
    .order_fwd(order_fwd), .sel_mask(sel_mask), .chan_sel(chan_sel),
    .chan_tag(chan_tag), .smp_valid(smp_valid)
  );

  function automatic logic [1:0] model(input logic [1:0] cur, input logic tm,
                                       input logic fw, input logic [2:0] m,
                                       input logic rs);
    logic [2:0] a;
    int ord [3];
    int idx;
    a = tm ? 3'b111 : m;
    if (a == 3'b000) return 2'd3;
    for (int i = 0; i < 3; i++) ord[i] = fw ? i : 2 - i;
    if ((rs && a == 3'b111) || cur == 2'd3 || !a[cur]) begin
      for (int i = 0; i < 3; i++) if (a[ord[i]]) return 2'(ord[i]);
    end
    idx = 0;
    for (int i = 0; i < 3; i++) if (ord[i] == int'(cur)) idx = i;
    for (int k = 1; k <= 3; k++) if (a[ord[(idx + k) % 3]]) return 2'(ord[(idx + k) % 3]);
    return 2'd3;
  endfunction

  function automatic string req_of(input logic tm, input logic fw, input logic [2:0] m);
    if (tm) return fw ? "R1" : "R2";
    if (m == 3'b111) return "R7";
    if (m == 3'b000) return "R6";
    if ($countones(m) == 1) return "R5";
    return "R4";
  endfunction

  task automatic check_out(input string req);
    logic [2:0] es;
    es = (exp_tag == 2'd3) ? 3'b000 : (3'b001 << exp_tag);
    checks++;
    if (chan_tag !== exp_tag) begin
      errors++;
      $display("FAIL %s tag actual %0d expected %0d", req, chan_tag, exp_tag);
    end
    checks++;
    if (chan_sel !== es || smp_valid !== (exp_tag != 2'd3)) begin
      errors++;
      $display("FAIL R9 sel/valid actual %b/%b expected %b/%b", chan_sel, smp_valid, es, exp_tag != 2'd3);
    end
  endtask

  task automatic cyc(input logic pv, input string req);
    logic rs;
    @(negedge clk);
    pix_clk = pv;
    rs = psh[1] & ~psh[2];
    exp_tag = model(exp_tag, tri_mode, order_fwd, sel_mask, rs);
    psh = {psh[1:0], pix_clk};
    @(negedge clk);
    check_out(req);
    pix_clk = pv;
  endtask

  task automatic step(input logic pv, input string req);
    logic rs;
    pix_clk = pv;
    rs = psh[1] & ~psh[2];
    exp_tag = model(exp_tag, tri_mode, order_fwd, sel_mask, rs);
    psh = {psh[1:0], pix_clk};
    @(negedge clk);
    check_out(req);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_out("R8");
    rst_n = 1'b1;
    tri_mode = 1'b1; order_fwd = 1'b1;
    step(1'b0, "R8");
    for (int i = 0; i < 6; i++) step(1'b0, "R1");

    for (int c = 0; c < 32; c++) begin
      tri_mode  = c[4];
      order_fwd = c[3];
      sel_mask  = c[2:0];
      for (int i = 0; i < 7; i++) step(1'b0, req_of(tri_mode, order_fwd, sel_mask));
    end

    for (int c = 0; c < 4; c++) begin
      tri_mode = c[0]; order_fwd = c[1]; sel_mask = 3'b111;
      step(1'b0, "R7");
      step(1'b0, "R3");
      step(1'b1, "R3");
      for (int i = 0; i < 8; i++) step(1'b1, "R3");
      step(1'b0, "R3");
      step(1'b1, "R3");
      step(1'b0, "R3");
      for (int i = 0; i < 3; i++) step(1'b0, "R3");
    end

    tri_mode = 1'b0; order_fwd = 1'b1; sel_mask = 3'b110;
    for (int i = 0; i < 2; i++) step(1'b0, "R10");
    step(1'b1, "R10");
    for (int i = 0; i < 5; i++) step(1'b0, "R10");
    sel_mask = 3'b100;
    for (int i = 0; i < 3; i++) step(1'b1, "R10");
    tri_mode = 1'b1; order_fwd = 1'b1;
    step(1'b0, "R1");
    step(1'b0, "R1");
    sel_mask = 3'b101; tri_mode = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b0, "R10");
    sel_mask = 3'b000;
    step(1'b0, "R6");
    step(1'b0, "R6");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule